// File: doc/BRIEF.md
# Stream-to-Memory Write Data Engine

This block drains a word stream into memory through the data and response channels of an AXI write port. A transfer is programmed with a start byte address and a word count. Words arriving on the stream input are held in a small FIFO and sent out as write-data beats, grouped into bursts of a fixed length. The address of the burst now being sent is exposed as a plain output so that a separate address generator can issue the matching address phase. A one-cycle done pulse marks the return of the last write response.

The input back-pressure is advisory. Every cycle with `s_valid` high carries a word that is taken, whatever `s_ready` shows. `s_ready` falling only asks upstream to stop, and upstream may take up to `SLACK` more cycles to do so. To cover this, the FIFO drops `s_ready` while there is still room for those late words. On the memory side the usual valid/ready rules apply. A beat stays presented, unchanged, until `m_wready` accepts it. Responses are always accepted. Every transaction uses ID zero, and response codes are not examined.

Top module: `stream_wr_engine`

## Requirements
- R1: After reset, `s_ready` is 1, `m_wvalid` is 0, `busy` is 0 and `done` is 0.
- R2: Every word presented with `s_valid` high during a transfer appears exactly once on `m_wdata`, in arrival order, including words presented while `s_ready` is low. No beat is issued beyond the programmed count.
- R3: `s_ready` is 1 exactly when the number of free FIFO entries is greater than `SLACK`. Upstream that sends up to `SLACK` words after `s_ready` falls never overflows the FIFO.
- R4: Beats are numbered from 0 within each burst. `m_wlast` is 1 on beat `BURST_LEN-1` of each burst and on the final word of the transfer, and is 0 on every other beat.
- R5: Once `m_wvalid` is 1 with `m_wready` 0, the next cycle still has `m_wvalid` at 1 with the same `m_wdata`.
- R6: On every valid beat, `m_wstrb` is all ones and `m_wid` is 0.
- R7: While burst k (counted from 0) is being sent, `burst_addr` equals the start address plus k·`BURST_LEN`·(`DATA_W`/8).
- R8: `done` is 1 for exactly one cycle: the cycle after the handshake of response number ceil(count/`BURST_LEN`). `busy` is 0 from that same cycle. The value of `m_bresp` changes nothing, and no beat is issued while `busy` is 0.
- R9: A `cfg_start` pulse while `busy` is 1 is ignored. The running transfer's data, burst addresses and beat count are unchanged.
- R10: `m_bready` is 1 at all times after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | 1 | Start a transfer (taken only when idle and count nonzero) |
| cfg_addr | input | ADDR_W | Byte address of the first burst |
| cfg_words | input | CNT_W | Number of words to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the final write response |
| burst_addr | output | ADDR_W | Byte address of the current burst |
| s_valid | input | 1 | Stream word present (always taken) |
| s_data | input | DATA_W | Stream word |
| s_ready | output | 1 | Advisory stop request when low |
| m_wvalid | output | 1 | Write beat valid |
| m_wready | input | 1 | Write beat accepted |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Byte strobes |
| m_wlast | output | 1 | Final beat of a burst |
| m_wid | output | ID_W | Write ID |
| m_bvalid | input | 1 | Write response valid |
| m_bresp | input | 2 | Write response code (not examined) |
| m_bready | output | 1 | Write response accepted |

## Verification
The bench sweeps every word count from one to a little over three bursts. Each count runs under four memory-acceptance patterns, and the slowest pattern drives the FIFO into its ready-low window. An upstream model that honours `s_ready` two cycles late catches a threshold one entry too tight as a lost word, and one too loose as a ready mismatch. Partial last bursts catch a `m_wlast` that only watches the beat counter, and also a done that waits for a response that never comes. Start pulses issued mid-transfer catch a design that reloads its counters and corrupts the running transfer's addresses.

// File: rtl/swe_pkg.sv
package swe_pkg;
  typedef enum logic {XF_IDLE = 1'b0, XF_RUN = 1'b1} xfer_state_e;

  function automatic int unsigned beat_bits(input int unsigned blen);
    return (blen > 1) ? $clog2(blen) : 1;
  endfunction
endpackage

// File: rtl/swe_fifo.sv
module swe_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned SLACK = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full,
  output logic             room_ok
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    fill;
  logic             do_wr, do_rd;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_rd   = pop && !empty;
  assign do_wr   = push && (!full || do_rd);
  assign empty   = (fill == '0);
  assign full    = (fill == CW'(DEPTH));
  assign room_ok = (CW'(DEPTH) - fill) > CW'(SLACK);
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_wr) wr_ptr <= nxt(wr_ptr);
      if (do_rd) rd_ptr <= nxt(rd_ptr);
      case ({do_wr, do_rd})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  // R3: a late word must always find room
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  // R2: the write side never takes a word that is not there
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/swe_beat_ctl.sv
module swe_beat_ctl #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned BURST_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_words,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              fifo_empty,
  input  logic              wready,
  output logic              wvalid,
  output logic              wlast,
  output logic              pop,
  output logic [ADDR_W-1:0] burst_addr
);
  localparam int unsigned BEAT_W = swe_pkg::beat_bits(BURST_LEN);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BURST_LEN * (DATA_W / 8));

  logic [CNT_W-1:0]  words_left;
  logic [BEAT_W-1:0] beat_q;
  logic [ADDR_W-1:0] addr_q;
  logic              end_of_burst;

  assign end_of_burst = (beat_q == BEAT_W'(BURST_LEN - 1)) || (words_left == CNT_W'(1));
  assign wvalid       = (words_left != '0) && !fifo_empty;
  assign wlast        = wvalid && end_of_burst;
  assign pop          = wvalid && wready;
  assign burst_addr   = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      words_left <= '0;
      beat_q     <= '0;
      addr_q     <= '0;
    end else if (load) begin
      words_left <= load_words;
      beat_q     <= '0;
      addr_q     <= load_addr;
    end else if (pop) begin
      words_left <= words_left - 1'b1;
      if (end_of_burst) begin
        beat_q <= '0;
        addr_q <= addr_q + STEP;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  // R4: a burst never runs past its length without a last beat
  assert_burst_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !wlast) |=> (beat_q != '0));
endmodule

// File: rtl/swe_resp_ctl.sv
module swe_resp_ctl #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned BURST_LEN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_words,
  input  logic             bvalid,
  input  logic [1:0]       bresp,
  output logic             bready,
  output logic             busy,
  output logic             done
);
  import swe_pkg::*;

  localparam int unsigned TW = CNT_W + 1;

  xfer_state_e   state_q;
  logic [TW-1:0] bursts_left;
  logic [TW-1:0] bursts_total;
  logic          resp_hs;

  assign bursts_total = ({1'b0, load_words} + TW'(BURST_LEN - 1)) / TW'(BURST_LEN);
  assign bready       = 1'b1;
  assign busy         = (state_q == XF_RUN);
  assign resp_hs      = bvalid && bready && busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= XF_IDLE;
      bursts_left <= '0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        state_q     <= XF_RUN;
        bursts_left <= bursts_total;
      end else if (resp_hs) begin
        bursts_left <= bursts_left - 1'b1;
        if (bursts_left == TW'(1)) begin
          state_q <= XF_IDLE;
          done    <= 1'b1;
        end
      end
    end
  end

  // R8: done is a single-cycle pulse and marks the end of the transfer
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8: response codes are taken as they come; only their presence matters
  assert_resp_known_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> !$isunknown(bresp));
endmodule

// File: rtl/stream_wr_engine.sv
module stream_wr_engine #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned ID_W       = 4,
  parameter int unsigned BURST_LEN  = 16,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned SLACK      = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_start,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [CNT_W-1:0]      cfg_words,
  output logic                  busy,
  output logic                  done,
  output logic [ADDR_W-1:0]     burst_addr,
  input  logic                  s_valid,
  input  logic [DATA_W-1:0]     s_data,
  output logic                  s_ready,
  output logic                  m_wvalid,
  input  logic                  m_wready,
  output logic [DATA_W-1:0]     m_wdata,
  output logic [DATA_W/8-1:0]   m_wstrb,
  output logic                  m_wlast,
  output logic [ID_W-1:0]       m_wid,
  input  logic                  m_bvalid,
  input  logic [1:0]            m_bresp,
  output logic                  m_bready
);
  logic load, fifo_empty, fifo_full, fifo_pop;

  assign load    = cfg_start && !busy && (cfg_words != '0);
  assign m_wstrb = '1;
  assign m_wid   = '0;

  swe_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH), .SLACK(SLACK)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(s_valid), .din(s_data),
    .pop(fifo_pop), .dout(m_wdata),
    .empty(fifo_empty), .full(fifo_full), .room_ok(s_ready)
  );

  swe_beat_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .BURST_LEN(BURST_LEN)) u_beat (
    .clk(clk), .rst_n(rst_n),
    .load(load), .load_words(cfg_words), .load_addr(cfg_addr),
    .fifo_empty(fifo_empty), .wready(m_wready),
    .wvalid(m_wvalid), .wlast(m_wlast), .pop(fifo_pop), .burst_addr(burst_addr)
  );

  swe_resp_ctl #(.CNT_W(CNT_W), .BURST_LEN(BURST_LEN)) u_resp (
    .clk(clk), .rst_n(rst_n),
    .load(load), .load_words(cfg_words),
    .bvalid(m_bvalid), .bresp(m_bresp), .bready(m_bready),
    .busy(busy), .done(done)
  );

  // R5: a stalled beat stays put
  assert_wvalid_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wvalid && !m_wready) |=> m_wvalid);
  assert_wdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wvalid && !m_wready) |=> $stable(m_wdata));
  // R8: no beat outside a running transfer
  assert_idle_no_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !m_wvalid);
  // R3: the FIFO never reaches full while stream input is still allowed
  assert_ready_margin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !fifo_full);
endmodule

// File: tb/sim_stream_wr_engine.sv
module sim_stream_wr_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, DW = 16, CW = 8, IW = 4, BL = 4, DEPTH = 8, SLACK = 2;

  logic clk = 0, rst_n = 0;
  logic cfg_start = 0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_words = '0;
  logic busy, done, s_ready, m_wvalid, m_wlast, m_bready;
  logic [AW-1:0] burst_addr;
  logic s_valid = 0;
  logic [DW-1:0] s_data = '0;
  logic m_wready = 0, m_bvalid = 0;
  logic [1:0] m_bresp = '0;
  logic [DW-1:0] m_wdata;
  logic [DW/8-1:0] m_wstrb;
  logic [IW-1:0] m_wid;

  int checks = 0, failures = 0, late_total = 0, wd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stream_wr_engine #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .ID_W(IW), .BURST_LEN(BL),
                     .FIFO_DEPTH(DEPTH), .SLACK(SLACK)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_addr(cfg_addr), .cfg_words(cfg_words),
    .busy(busy), .done(done), .burst_addr(burst_addr),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
    .m_wlast(m_wlast), .m_wid(m_wid), .m_bvalid(m_bvalid), .m_bresp(m_bresp), .m_bready(m_bready)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] expw(input int xid, input int i);
    return DW'(((xid & 255) << 8) | (i & 255));
  endfunction

  function automatic bit wr_rdy(input int mode, input int cyc);
    case (mode)
      0: return 1'b1;
      1: return cyc[0];
      2: return ((cyc * 7 + 3) % 5) != 0;
      default: return (cyc % 4) == 0;
    endcase
  endfunction

  function automatic bit src_go(input int mode, input int cyc);
    case (mode)
      1: return (cyc % 5) != 4;
      2: return (cyc % 3) != 2;
      default: return 1'b1;
    endcase
  endfunction

  task automatic run_xfer(input int count, input int mode, input int xid, input bit poke);
    int sent = 0, beat = 0, pend = 0, resp = 0, last_cyc = -1, cyc = 0, occ = 0;
    int nb = (count + BL - 1) / BL;
    bit r1 = 1, r2 = 1, prev_stall = 0, finished = 0;
    logic [DW-1:0] prev_data = '0;
    logic [AW-1:0] base = 32'h0001_0000 + AW'(xid) * 32'h200;
    @(negedge clk);
    cfg_start = 1; cfg_addr = base; cfg_words = CW'(count);
    while (!finished && cyc < 3000) begin
      int push = 0, pop = 0, pend_new = 0;
      bit wr;
      @(negedge clk);
      cfg_start = 0;
      if (poke && cyc == 2) begin
        cfg_start = 1; cfg_addr = 32'hdead_0000; cfg_words = 8'd5;
      end
      // R3: exact ready threshold against the model's occupancy
      chk(s_ready === ((DEPTH - occ) > SLACK), "R3 s_ready threshold", s_ready, (DEPTH - occ) > SLACK);
      if (prev_stall) begin
        chk(m_wvalid === 1'b1, "R5 wvalid held", m_wvalid, 1);
        chk(m_wdata === prev_data, "R5 wdata held", m_wdata, prev_data);
      end
      wr = wr_rdy(mode, cyc);
      m_wready = wr;
      if (m_wvalid) begin
        bit lexp = ((beat % BL) == BL - 1) || (beat == count - 1);
        chk(beat < count, "R2 beat beyond count", beat, count);
        chk(m_wdata === expw(xid, beat), poke ? "R9 R2 data order" : "R2 data order", m_wdata, expw(xid, beat));
        chk(m_wlast === lexp, "R4 wlast", m_wlast, lexp);
        chk(m_wstrb === '1 && m_wid === '0, "R6 strobe and id", {m_wstrb, m_wid}, {2'b11, 4'h0});
        if (beat % BL == 0)
          chk(burst_addr === base + AW'((beat / BL) * BL * (DW / 8)), poke ? "R9 R7 burst address" : "R7 burst address",
              burst_addr, base + AW'((beat / BL) * BL * (DW / 8)));
        prev_stall = !wr;
        prev_data = m_wdata;
        if (wr) begin
          pop = 1;
          if (lexp) pend_new = 1;
          beat++;
        end
      end else begin
        prev_stall = 0;
      end
      // memory model: responses after completed bursts, with varied codes (R8)
      if (pend > 0) begin
        m_bvalid = 1; m_bresp = 2'(resp % 4);
        pend--; resp++;
        if (resp == nb) last_cyc = cyc;
      end else begin
        m_bvalid = 0;
      end
      pend += pend_new;
      if (last_cyc >= 0 && cyc == last_cyc + 1) begin
        chk(done === 1'b1, "R8 done pulse", done, 1);
        chk(busy === 1'b0, "R8 busy cleared", busy, 0);
      end else if (done) begin
        chk(1'b0, "R8 unexpected done", done, 0);
      end
      if (last_cyc >= 0 && cyc == last_cyc + 2) begin
        chk(done === 1'b0, "R8 done one cycle", done, 0);
        chk(m_wvalid === 1'b0, "R8 no beat when idle", m_wvalid, 0);
        chk(beat == count, poke ? "R9 beat count" : "R2 beat count", beat, count);
        finished = 1;
      end
      // upstream honours s_ready two samples late (R3 slack)
      if (!finished && sent < count && r2 && src_go(mode, cyc)) begin
        s_valid = 1; s_data = expw(xid, sent); sent++; push = 1;
        if (!s_ready) late_total++;
      end else begin
        s_valid = 0;
      end
      r2 = r1; r1 = s_ready;
      occ += push - pop;
      cyc++;
    end
    if (!finished) chk(1'b0, "R8 transfer did not complete", cyc, 0);
    @(negedge clk);
    m_bvalid = 0; s_valid = 0; m_wready = 0;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      failures++;
      checks++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", wd, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(s_ready === 1'b1, "R1 s_ready after reset", s_ready, 1);
    chk(m_wvalid === 1'b0, "R1 wvalid after reset", m_wvalid, 0);
    chk(busy === 1'b0, "R1 busy after reset", busy, 0);
    chk(done === 1'b0, "R1 done after reset", done, 0);
    chk(m_bready === 1'b1, "R10 bready", m_bready, 1);
    for (int mode = 0; mode < 4; mode++) begin
      for (int n = 1; n <= 13; n++) begin
        run_xfer(n, mode, mode * 16 + n, (n % 4) == 3);
        chk(m_bready === 1'b1, "R10 bready held", m_bready, 1);
      end
    end
    chk(late_total > 0, "R3 words taken while s_ready low", late_total, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule